// File: doc/BRIEF.md
# Ethernet station address handler

This block keeps the 48-bit station address of an Ethernet MAC and applies it to both directions of a byte-wide frame stream. Each stream carries a valid strobe and start and end markers. Software loads the address through two 32-bit configuration words. A single stored image serves both uses, and each use has its own enable.

On the transmit side, the block can stamp the station address into the source-address field of client frames. Frames that the MAC generates internally, flagged as control frames at their start, always get the station address. On the receive side, the block drops unicast frames whose destination does not match the station address. An accept-all-unicast input turns that filter off. Multicast and broadcast frames are never filtered.

Both paths are six-stage delay lines with a fixed latency of six clock cycles. Inside a frame the valid strobe must stay high from the start marker through the end marker. The block samples the address at each start of frame, so a frame never mixes old and new address bytes.

Top module: `station_addr_filter`

## Requirements
- R1: Configuration word 0 (`cfg_wr_sel`=0) holds address bits 31:0 and reads back what was written. Both words read 0 after reset.
- R2: Word 1 (`cfg_wr_sel`=1) stores only bits 15:0, as address bits 47:32. Its bits 31:16 always read 0, whatever was written to them. The first byte on the wire is address bits 47:40 (word 1 bits 15:8) and the sixth is bits 7:0 (word 0 bits 7:0).
- R3: Every transmit byte leaves exactly 6 cycles after it enters, with its start and end markers. When neither override nor control is set for a frame, its data is unchanged.
- R4: When `tx_src_override` is 1 at a frame's start, bytes 6 to 11 of a frame of 12 or more bytes become the station address in wire order. Byte 6 is address bits 47:40.
- R5: A frame whose `tx_in_ctrl` is 1 on its start byte has bytes 6 to 11 replaced, even when override is 0.
- R6: A transmit frame shorter than 12 bytes leaves unchanged, even when override or control is set.
- R7: A receive frame is unicast when bit 0 of its first byte is 0. With `rx_accept_all_ucast`=0, a unicast frame whose first six bytes differ from the station address produces no output byte. `rx_drop` then pulses for one cycle.
- R8: Receive frames that match, multicast or broadcast frames, and any frame received while `rx_accept_all_ucast`=1 come out unchanged after 6 cycles.
- R9: A receive frame shorter than 6 bytes produces no output and one `rx_drop` pulse.
- R10: Each frame uses the address stored at the start of its start-of-frame cycle. A write during a frame applies from the next frame on.
- R11: `cfg_error` is 1 one cycle after `mac_enable` is 1 while the stored address is zero, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Word select for writes (0 low word, 1 high word) |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 1 | Word select for reads |
| cfg_rd_data | output | 32 | Read data of the selected word |
| mac_enable | input | 1 | MAC enabled |
| cfg_error | output | 1 | Enabled with an all-zero address |
| tx_src_override | input | 1 | Replace the source address of client frames |
| rx_accept_all_ucast | input | 1 | Disable unicast destination filtering |
| tx_in_valid | input | 1 | Transmit input byte valid |
| tx_in_sof | input | 1 | Transmit input start of frame |
| tx_in_eof | input | 1 | Transmit input end of frame |
| tx_in_ctrl | input | 1 | Frame is internally generated control (sampled at start) |
| tx_in_data | input | 8 | Transmit input byte |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_sof | output | 1 | Transmit output start of frame |
| tx_out_eof | output | 1 | Transmit output end of frame |
| tx_out_data | output | 8 | Transmit output byte |
| rx_in_valid | input | 1 | Receive input byte valid |
| rx_in_sof | input | 1 | Receive input start of frame |
| rx_in_eof | input | 1 | Receive input end of frame |
| rx_in_data | input | 8 | Receive input byte |
| rx_out_valid | output | 1 | Receive output byte valid |
| rx_out_sof | output | 1 | Receive output start of frame |
| rx_out_eof | output | 1 | Receive output end of frame |
| rx_out_data | output | 8 | Receive output byte |
| rx_drop | output | 1 | One-cycle pulse per discarded frame |

## Verification
The assertions check on every cycle the things a property can relate directly. A configuration write shows up on the read port in the next cycle, and the high word's reserved half stays zero. No output byte appears on either path unless an input byte entered six cycles earlier. The first byte of a transmit frame passes through untouched, and the error flag never rises unless the MAC was enabled. Only the bench scenarios can show the rest: which bytes get replaced, whether a whole receive frame disappears, short-frame handling at the 6- and 12-byte limits, and an address write in the middle of a frame landing at the next frame boundary.

// File: rtl/station_addr_filter.sv
module station_addr_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic        cfg_wr_sel,
  input  logic [31:0] cfg_wr_data,
  input  logic        cfg_rd_sel,
  output logic [31:0] cfg_rd_data,
  input  logic        mac_enable,
  output logic        cfg_error,
  input  logic        tx_src_override,
  input  logic        rx_accept_all_ucast,
  input  logic        tx_in_valid,
  input  logic        tx_in_sof,
  input  logic        tx_in_eof,
  input  logic        tx_in_ctrl,
  input  logic [7:0]  tx_in_data,
  output logic        tx_out_valid,
  output logic        tx_out_sof,
  output logic        tx_out_eof,
  output logic [7:0]  tx_out_data,
  input  logic        rx_in_valid,
  input  logic        rx_in_sof,
  input  logic        rx_in_eof,
  input  logic [7:0]  rx_in_data,
  output logic        rx_out_valid,
  output logic        rx_out_sof,
  output logic        rx_out_eof,
  output logic [7:0]  rx_out_data,
  output logic        rx_drop
);

  localparam int DLY = 6;

  logic [47:0] station;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      station   <= '0;
      cfg_error <= 1'b0;
    end else begin
      if (cfg_wr_en) begin
        if (cfg_wr_sel) station[47:32] <= cfg_wr_data[15:0];
        else            station[31:0]  <= cfg_wr_data;
      end
      cfg_error <= mac_enable && (station == 48'h0);
    end
  end

  assign cfg_rd_data = cfg_rd_sel ? {16'h0, station[47:32]} : station[31:0];

  // transmit: six-stage line, source field patched when byte 11 arrives
  logic [DLY-1:0] tv, ts, te;
  logic [7:0]     td [DLY];
  logic [3:0]     tcnt, tidx;
  logic [47:0]    tsnap;
  logic           trep, t11;

  assign tidx = tx_in_sof ? 4'd0 : tcnt;
  assign t11  = tx_in_valid && trep && (tidx == 4'd11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tv <= '0; ts <= '0; te <= '0;
      tcnt <= '0; tsnap <= '0; trep <= 1'b0;
      for (int i = 0; i < DLY; i++) td[i] <= 8'h0;
    end else begin
      tv <= {tv[DLY-2:0], tx_in_valid};
      ts <= {ts[DLY-2:0], tx_in_valid & tx_in_sof};
      te <= {te[DLY-2:0], tx_in_valid & tx_in_eof};
      td[0] <= t11 ? tsnap[7:0] : tx_in_data;
      for (int i = 0; i < DLY-1; i++)
        td[i+1] <= t11 ? tsnap[8*i+8 +: 8] : td[i];
      if (tx_in_valid) begin
        tcnt <= (tidx == 4'd15) ? tidx : tidx + 4'd1;
        if (tx_in_sof) begin
          tsnap <= station;
          trep  <= tx_src_override | tx_in_ctrl;
        end
      end
    end
  end

  assign tx_out_valid = tv[DLY-1];
  assign tx_out_sof   = ts[DLY-1];
  assign tx_out_eof   = te[DLY-1];
  assign tx_out_data  = td[DLY-1];

  // receive: six-stage line, whole frame squashed when its verdict is known
  logic [DLY-1:0] rv, rs, re;
  logic [7:0]     rd [DLY];
  logic [3:0]     rcnt, ridx;
  logic [47:0]    rsnap, rdest;
  logic           rdropping, rat5, rkill, rrunt, rkeep;
  logic [DLY-2:0] rmask;

  assign ridx  = rx_in_sof ? 4'd0 : rcnt;
  assign rdest = {rd[4], rd[3], rd[2], rd[1], rd[0], rx_in_data};
  assign rat5  = rx_in_valid && !rdropping && (ridx == 4'd5);
  assign rkill = rat5 && !rd[4][0] && !rx_accept_all_ucast && (rdest != rsnap);
  assign rrunt = rx_in_valid && rx_in_eof && (ridx < 4'd5);
  assign rkeep = rx_in_valid && !rdropping && !rkill && !rrunt;

  for (genvar g = 0; g < DLY-1; g++) begin : g_mask
    assign rmask[g] = rkill || (rrunt && (ridx > 4'(g)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv <= '0; rs <= '0; re <= '0;
      rcnt <= '0; rsnap <= '0; rdropping <= 1'b0; rx_drop <= 1'b0;
      for (int i = 0; i < DLY; i++) rd[i] <= 8'h0;
    end else begin
      rv <= {rv[DLY-2:0] & ~rmask, rkeep};
      rs <= {rs[DLY-2:0], rx_in_sof};
      re <= {re[DLY-2:0], rx_in_eof};
      rd[0] <= rx_in_data;
      for (int i = 0; i < DLY-1; i++) rd[i+1] <= rd[i];
      rx_drop <= rkill || rrunt;
      if (rx_in_valid) begin
        rcnt <= (ridx == 4'd15) ? ridx : ridx + 4'd1;
        if (rx_in_sof) rsnap <= station;
        if (rx_in_eof)  rdropping <= 1'b0;
        else if (rkill) rdropping <= 1'b1;
      end
    end
  end

  assign rx_out_valid = rv[DLY-1];
  assign rx_out_sof   = rv[DLY-1] & rs[DLY-1];
  assign rx_out_eof   = rv[DLY-1] & re[DLY-1];
  assign rx_out_data  = rd[DLY-1];

endmodule

// File: rtl/station_addr_filter_chk.sv
module station_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic        cfg_wr_sel,
  input logic [31:0] cfg_wr_data,
  input logic        cfg_rd_sel,
  input logic [31:0] cfg_rd_data,
  input logic        mac_enable,
  input logic        cfg_error,
  input logic        tx_in_valid,
  input logic [7:0]  tx_in_data,
  input logic        tx_out_valid,
  input logic        tx_out_sof,
  input logic [7:0]  tx_out_data,
  input logic        rx_in_valid,
  input logic        rx_out_valid
);

  a_r1_word0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_wr_sel) |=> (cfg_rd_sel || cfg_rd_data == $past(cfg_wr_data)));

  a_r2_word1_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_sel) |=> (!cfg_rd_sel || cfg_rd_data == {16'h0, $past(cfg_wr_data[15:0])}));

  a_r3_tx_latency: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> $past(tx_in_valid, 6));

  a_r3_tx_head_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_sof |-> (tx_out_data == $past(tx_in_data, 6)));

  a_r8_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> $past(rx_in_valid, 6));

  a_r11_cfg_error: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> $past(mac_enable));

endmodule

bind station_addr_filter station_addr_filter_chk u_chk (.*);

// File: tb/station_addr_filter_bench.sv
`timescale 1ns/1ps
module station_addr_filter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_en = 0, cfg_wr_sel = 0, cfg_rd_sel = 0;
  logic [31:0] cfg_wr_data = '0, cfg_rd_data;
  logic mac_enable = 0, cfg_error, tx_src_override = 0, rx_accept_all_ucast = 0;
  logic tx_in_valid = 0, tx_in_sof = 0, tx_in_eof = 0, tx_in_ctrl = 0;
  logic [7:0] tx_in_data = '0, tx_out_data, rx_in_data = '0, rx_out_data;
  logic tx_out_valid, tx_out_sof, tx_out_eof;
  logic rx_in_valid = 0, rx_in_sof = 0, rx_in_eof = 0;
  logic rx_out_valid, rx_out_sof, rx_out_eof, rx_drop;

  always #2.5 clk = ~clk;

  station_addr_filter u_station_addr_filter (.*);

  int checks = 0, failures = 0, exp_drops = 0, obs_drops = 0;
  bit finished = 0;
  logic [47:0] m_addr = '0;
  logic [9:0] txq[$], rxq[$];
  string txtag[$], rxtag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: pop expected bytes as the design emits them
  always @(negedge clk) if (rst_n) begin
    if (tx_out_valid) begin
      if (txq.size() == 0) chk(0, "R3", "unexpected tx byte", {tx_out_sof, tx_out_eof, tx_out_data}, 0);
      else chk({tx_out_sof, tx_out_eof, tx_out_data} == txq[0], txtag[0], "tx byte",
               {tx_out_sof, tx_out_eof, tx_out_data}, txq[0]);
      if (txq.size() != 0) begin void'(txq.pop_front()); void'(txtag.pop_front()); end
    end
    if (rx_out_valid) begin
      if (rxq.size() == 0) chk(0, "R7", "unexpected rx byte", {rx_out_sof, rx_out_eof, rx_out_data}, 0);
      else chk({rx_out_sof, rx_out_eof, rx_out_data} == rxq[0], rxtag[0], "rx byte",
               {rx_out_sof, rx_out_eof, rx_out_data}, rxq[0]);
      if (rxq.size() != 0) begin void'(rxq.pop_front()); void'(rxtag.pop_front()); end
    end
    if (rx_drop) obs_drops++;
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      tx_in_valid = 0; tx_in_sof = 0; tx_in_eof = 0; tx_in_ctrl = 0;
      rx_in_valid = 0; rx_in_sof = 0; rx_in_eof = 0;
    end
  endtask

  task automatic send_tx(input int len, input logic [7:0] seed, input bit ctrl, input string tag);
    bit rep = (tx_src_override || ctrl) && len >= 12;
    logic [47:0] a = m_addr;
    for (int j = 0; j < len; j++) begin
      logic [7:0] b = seed + 8'(j);
      logic [7:0] e = (rep && j >= 6 && j < 12) ? a[47-8*(j-6) -: 8] : b;
      txq.push_back({j == 0, j == len-1, e}); txtag.push_back(tag);
      @(negedge clk);
      tx_in_valid = 1; tx_in_sof = (j == 0); tx_in_eof = (j == len-1);
      tx_in_ctrl = ctrl; tx_in_data = b;
    end
  endtask

  task automatic send_rx(input int len, input logic [47:0] dest, input logic [7:0] seed, input string tag);
    bit pass = len >= 6 && (dest[40] || rx_accept_all_ucast || dest == m_addr);
    if (!pass) exp_drops++;
    for (int j = 0; j < len; j++) begin
      logic [7:0] b = (j < 6) ? dest[47-8*j -: 8] : seed + 8'(j);
      if (pass) begin rxq.push_back({j == 0, j == len-1, b}); rxtag.push_back(tag); end
      @(negedge clk);
      rx_in_valid = 1; rx_in_sof = (j == 0); rx_in_eof = (j == len-1); rx_in_data = b;
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 0;
    if (sel) m_addr[47:32] = d[15:0]; else m_addr[31:0] = d;
  endtask

  task automatic rd_chk(input bit sel, input logic [31:0] exp, input string tag);
    @(negedge clk); cfg_rd_sel = sel; #1;
    chk(cfg_rd_data == exp, tag, "config read", cfg_rd_data, exp);
  endtask

  task automatic drops_chk(input string tag);
    idle(12);
    chk(obs_drops == exp_drops, tag, "drop pulse count", obs_drops, exp_drops);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // reset state (R1, R11)
    rd_chk(0, 32'h0, "R1");
    rd_chk(1, 32'h0, "R1");
    chk(!tx_out_valid && !rx_out_valid && !rx_drop && !cfg_error, "R1", "outputs idle after reset", 0, 0);

    // R11: enabled with zero address
    @(negedge clk); mac_enable = 1;
    @(negedge clk);
    chk(cfg_error == 1'b1, "R11", "error with zero address", cfg_error, 1);

    // R1 / R2: address 00-1C-23-17-4A-CB, junk in reserved bits
    cfg_write(0, 32'h23174ACB);
    cfg_write(1, 32'hABCD001C);
    rd_chk(0, 32'h23174ACB, "R1");
    rd_chk(1, 32'h0000001C, "R2");
    chk(m_addr == 48'h001C23174ACB, "R2", "wire order model", m_addr, 48'h001C23174ACB);
    @(negedge clk);
    chk(cfg_error == 1'b0, "R11", "error clears with nonzero address", cfg_error, 0);

    // transmit
    tx_src_override = 0;
    send_tx(20, 8'h10, 0, "R3"); idle(2);
    @(negedge clk); tx_src_override = 1;
    send_tx(20, 8'h30, 0, "R4");
    send_tx(12, 8'h50, 0, "R4");
    send_tx(11, 8'h60, 0, "R6");
    send_tx(7,  8'h70, 0, "R6");
    send_tx(13, 8'h80, 0, "R4");
    idle(2);
    @(negedge clk); tx_src_override = 0;
    send_tx(14, 8'h90, 1, "R5");
    send_tx(9,  8'hA0, 1, "R6");
    send_tx(14, 8'hB0, 0, "R3");
    idle(2);

    // R10 transmit: write mid-frame, used only by the next frame
    @(negedge clk); tx_src_override = 1;
    fork
      send_tx(16, 8'hC0, 0, "R10");
      begin repeat (4) @(negedge clk); cfg_wr_en = 1; cfg_wr_sel = 0; cfg_wr_data = 32'h11223344;
            @(negedge clk); cfg_wr_en = 0; end
    join
    m_addr[31:0] = 32'h11223344;
    send_tx(16, 8'hD0, 0, "R10");
    idle(10);

    // receive
    send_rx(10, m_addr, 8'h00, "R8");
    send_rx(10, 48'h001C23999999, 8'h00, "R7");
    send_rx(8,  48'hFFFFFFFFFFFF, 8'h20, "R8");
    send_rx(9,  48'h0100_5E00_0001, 8'h30, "R8");
    send_rx(6,  m_addr, 8'h40, "R8");
    send_rx(6,  48'h020000000001, 8'h40, "R7");
    send_rx(7,  m_addr, 8'h48, "R8");
    drops_chk("R7");
    send_rx(3, m_addr, 8'h50, "R9");
    send_rx(1, m_addr, 8'h58, "R9");
    send_rx(5, m_addr, 8'h60, "R9");
    send_rx(8, m_addr, 8'h68, "R9");
    drops_chk("R9");
    @(negedge clk); rx_accept_all_ucast = 1;
    send_rx(10, 48'h0A0B0C0D0E0F, 8'h70, "R8");
    send_rx(4,  48'h0A0B0C0D0E0F, 8'h70, "R9");
    idle(1);
    @(negedge clk); rx_accept_all_ucast = 0;
    drops_chk("R8");

    // R10 receive: address changes while a matching frame is in flight
    fork
      send_rx(12, m_addr, 8'h80, "R10");
      begin repeat (2) @(negedge clk); cfg_wr_en = 1; cfg_wr_sel = 1; cfg_wr_data = 32'h00000AAA;
            @(negedge clk); cfg_wr_en = 0; end
    join
    begin
      logic [47:0] old = m_addr;
      m_addr[47:32] = 16'h0AAA;
      send_rx(10, old, 8'h90, "R10");
      send_rx(10, m_addr, 8'hA0, "R10");
    end
    drops_chk("R10");

    idle(10);
    chk(txq.size() == 0, "R3", "tx bytes outstanding", txq.size(), 0);
    chk(rxq.size() == 0, "R8", "rx bytes outstanding", rxq.size(), 0);
    finish_up();
  end
endmodule